// File: doc/BRIEF.md
# Bit-Serial Restoring Divider

This block divides one non-negative word by another, one bit of arithmetic per clock. The divisor sits in a circulating shift loop. A second loop holds the working partial remainder, and it is fed the dividend one bit at a time, most significant bit first. For each quotient position the block shifts the partial remainder left and appends the next dividend bit. It then runs the shifted value and the divisor, least significant bit first, through a single full adder. The divisor enters that adder complemented, and the carry is preset to one.

When the last difference bit has been captured, its top bit gives the sign. A discriminator reads that sign and does two things. It picks either the difference or the unchanged shifted value as the next partial remainder. It also emits the quotient bit, which is one exactly when the difference is not negative. The quotient bits gather in their own register.

A user applies both operands and pulses `start`. After a fixed number of cycles, `done` rises, and the quotient and remainder stay valid until the next accepted start. The divisor must be nonzero. A zero divisor is not detected.

Top module: `restoring_serial_divider`

## Requirements
- R1: After reset, `done` is 0, `quotient` is 0 and `remainder` is 0.
- R2: A `start` pulse seen while the block is idle captures `dividend` and `divisor` and clears `done` in the next cycle. `done` then rises exactly W*(W+3) clock cycles after the cycle in which `start` was taken: each of the W quotient bits costs W+2 serial subtract cycles plus one select cycle.
- R3: When `done` is 1, `quotient` equals the integer quotient floor(dividend/divisor) of the captured operands, for any nonzero divisor.
- R4: When `done` is 1, `remainder` equals dividend mod divisor of the captured operands, and it is smaller than the divisor.
- R5: A `start` pulse while a division is in progress is ignored. The running division keeps its operands and its completion cycle.
- R6: While `done` is 1 and no new start arrives, `done`, `quotient` and `remainder` hold their values, whatever the operand inputs do.
- R7: In every iteration, the quotient bit shifted into `quotient` bit 0 is 1 exactly when the shifted partial remainder is at least the divisor. The newly selected partial remainder is always below the divisor.
- R8: The boundary cases give exact results:
  - a dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend;
  - a divisor of 1 gives the dividend as quotient and remainder 0;
  - a zero dividend gives 0 and 0;
  - all-ones operands give quotient 1 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | W | Dividend, sampled on an accepted start |
| divisor | input | W | Divisor, nonzero, sampled on an accepted start |
| done | output | 1 | Result valid flag |
| quotient | output | W | Quotient, valid while done is 1 |
| remainder | output | W | Remainder, valid while done is 1 |

## Verification
The assertions check the following every cycle:
- each select step's quotient bit against a direct magnitude comparison of the shifted remainder and the divisor;
- that each new partial remainder stays below the divisor;
- the exact completion latency;
- that the results hold while done is 1;
- that each finished result satisfies quotient*divisor+remainder = dividend with the remainder below the divisor.

Only the bench scenarios can show the rest. These are the exact values for particular operands and the boundary cases. They also cover the reset state, and whether a start pulse sent in the middle of a run is really ignored rather than restarting the run with new operands.

// File: rtl/rsd_pkg.sv
`timescale 1ns/1ps
package rsd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SUB  = 2'd1,
    PH_SEL  = 2'd2
  } phase_t;

  // one-bit full adder, sum output
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // one-bit full adder, carry output
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rsd_serial_sub.sv
`timescale 1ns/1ps
// Serial subtractor: minuend minus subtrahend, LSB first.
// The subtrahend is complemented and the carry preset to one.
module rsd_serial_sub
  import rsd_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset,
  input  logic          en,
  input  logic          m_bit,
  input  logic          s_bit,
  output logic [SW-1:0] diff_word
);

  logic carry_q;
  logic sum_bit;
  logic s_inv;

  assign s_inv   = ~s_bit;
  assign sum_bit = fa_sum(m_bit, s_inv, carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q   <= 1'b0;
      diff_word <= '0;
    end else if (preset) begin
      carry_q <= 1'b1;
    end else if (en) begin
      carry_q   <= fa_carry(m_bit, s_inv, carry_q);
      diff_word <= {sum_bit, diff_word[SW-1:1]};
    end
  end

endmodule

// File: rtl/rsd_discriminator.sv
`timescale 1ns/1ps
// Chooses the next partial remainder from two candidates by the sign
// of the completed difference, and emits the quotient bit.
module rsd_discriminator #(
  parameter int W = 30
) (
  input  logic         sign,
  input  logic [W-1:0] cand_keep,
  input  logic [W-1:0] cand_diff,
  output logic [W-1:0] new_rem,
  output logic         qbit
);

  always_comb begin
    if (sign) begin
      new_rem = cand_keep;
      qbit    = 1'b0;
    end else begin
      new_rem = cand_diff;
      qbit    = 1'b1;
    end
  end

endmodule

// File: rtl/rsd_sequencer.sv
`timescale 1ns/1ps
// Timing network: serial subtract phase, then one select cycle, per bit.
module rsd_sequencer
  import rsd_pkg::*;
#(
  parameter int W  = 30,
  parameter int SW = W + 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic load,
  output logic sub_en,
  output logic sel_fire,
  output logic last_iter,
  output logic preset,
  output logic done
);

  localparam int BW = $clog2(SW);
  localparam int IW = $clog2(W);

  phase_t        phase;
  logic [BW-1:0] bit_cnt;
  logic [IW-1:0] iter_cnt;

  assign idle      = (phase == PH_IDLE);
  assign load      = start && idle;
  assign sub_en    = (phase == PH_SUB);
  assign sel_fire  = (phase == PH_SEL);
  assign last_iter = (iter_cnt == IW'(W - 1));
  assign preset    = load || (sel_fire && !last_iter);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      iter_cnt <= '0;
      done     <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_SUB;
            bit_cnt  <= '0;
            iter_cnt <= '0;
            done     <= 1'b0;
          end
        end
        PH_SUB: begin
          if (bit_cnt == BW'(SW - 1)) phase <= PH_SEL;
          else                        bit_cnt <= bit_cnt + 1'b1;
        end
        PH_SEL: begin
          bit_cnt <= '0;
          if (last_iter) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            iter_cnt <= iter_cnt + 1'b1;
            phase    <= PH_SUB;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/restoring_serial_divider.sv
`timescale 1ns/1ps
module restoring_serial_divider #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int SW = W + 2;  // shifted remainder W+1 bits plus sign

  logic [SW-1:0] rem_loop;
  logic [SW-1:0] div_loop;
  logic [W-1:0]  dvd_sr;
  logic [W-1:0]  quo_q;
  logic [SW-1:0] diff_word;

  logic seq_idle, load, sub_en, sel_fire, last_iter, preset;
  logic sign;
  logic qbit;
  logic [W:0]   cand_shift;
  logic [W-1:0] div_word;
  logic [W-1:0] new_rem;

  rsd_sequencer #(.W(W), .SW(SW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idle      (seq_idle),
    .load      (load),
    .sub_en    (sub_en),
    .sel_fire  (sel_fire),
    .last_iter (last_iter),
    .preset    (preset),
    .done      (done)
  );

  rsd_serial_sub #(.SW(SW)) u_sub (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset    (preset),
    .en        (sub_en),
    .m_bit     (rem_loop[0]),
    .s_bit     (div_loop[0]),
    .diff_word (diff_word)
  );

  assign sign       = diff_word[SW-1];
  assign cand_shift = rem_loop[W:0];
  assign div_word   = div_loop[W-1:0];

  rsd_discriminator #(.W(W)) u_disc (
    .sign      (sign),
    .cand_keep (cand_shift[W-1:0]),
    .cand_diff (diff_word[W-1:0]),
    .new_rem   (new_rem),
    .qbit      (qbit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_loop <= '0;
      div_loop <= '0;
      dvd_sr   <= '0;
      quo_q    <= '0;
    end else if (load) begin
      div_loop <= {2'b00, divisor};
      rem_loop <= {{(SW-1){1'b0}}, dividend[W-1]};
      dvd_sr   <= {dividend[W-2:0], 1'b0};
      quo_q    <= '0;
    end else if (sub_en) begin
      rem_loop <= {rem_loop[0], rem_loop[SW-1:1]};
      div_loop <= {div_loop[0], div_loop[SW-1:1]};
    end else if (sel_fire) begin
      quo_q  <= {quo_q[W-2:0], qbit};
      dvd_sr <= {dvd_sr[W-2:0], 1'b0};
      if (last_iter) rem_loop <= {2'b00, new_rem};
      else           rem_loop <= {1'b0, new_rem, dvd_sr[W-1]};
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_loop[W-1:0];

endmodule

// File: rtl/rsd_checker.sv
`timescale 1ns/1ps
module rsd_checker #(
  parameter int W = 30
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         idle,
  input logic         sel_fire,
  input logic [W:0]   cand_shift,
  input logic [W-1:0] div_word,
  input logic [W-1:0] new_rem
);

  localparam int LAT = W * (W + 3);

  logic [31:0]    lat_cnt;
  logic [W-1:0]   cap_n;
  logic [W-1:0]   cap_d;
  logic [2*W-1:0] recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      cap_n   <= '0;
      cap_d   <= '0;
    end else if (start && idle) begin
      lat_cnt <= '0;
      cap_n   <= dividend;
      cap_d   <= divisor;
    end else if (!idle) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  always_comb recon = ({{W{1'b0}}, quotient} * {{W{1'b0}}, cap_d}) + {{W{1'b0}}, remainder};

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> !done);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (lat_cnt == 32'(LAT)));

  // R5: only accepted starts update cap_n/cap_d, so a mid-run start must not alter the result
  assert_quotient_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (recon == {{W{1'b0}}, cap_n}));

  assert_remainder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (remainder < cap_d));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder)));

  assert_rem_below_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |-> (new_rem < div_word));

  assert_qbit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fire |=> (quotient[0] == ($past(cand_shift) >= {1'b0, $past(div_word)})));

endmodule

bind restoring_serial_divider rsd_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .dividend   (dividend),
  .divisor    (divisor),
  .done       (done),
  .quotient   (quotient),
  .remainder  (remainder),
  .idle       (seq_idle),
  .sel_fire   (sel_fire),
  .cand_shift (cand_shift),
  .div_word   (div_word),
  .new_rem    (new_rem)
);

// File: tb/restoring_serial_divider_bench.sv
`timescale 1ns/1ps
module restoring_serial_divider_bench;

  localparam int W   = 30;
  localparam int LAT = W * (W + 3);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  restoring_serial_divider #(.W(W)) u_restoring_serial_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse start, count cycles to done, check R2 latency/clear and R3/R4 results
  task automatic t_divide(input logic [W-1:0] n, input logic [W-1:0] d, input string tag);
    int cyc;
    @(negedge clk);
    dividend = n;
    divisor  = d;
    start    = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    check(done == 1'b0, {tag, " R2 done cleared"}, 64'(done), 64'd0);
    cyc = 0;
    while (!done && cyc < LAT + 20) begin
      @(posedge clk);
      cyc++;
      #1;
    end
    check(cyc == LAT, {tag, " R2 latency"}, 64'(cyc), 64'(LAT));
    check(quotient == n / d, {tag, " R3 quotient"}, 64'(quotient), 64'(n / d));
    check(remainder == n % d, {tag, " R4 remainder"}, 64'(remainder), 64'(n % d));
  endtask

  task automatic t_reset();
    #1;
    check(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    check(quotient == '0, "R1 reset quotient", 64'(quotient), 64'd0);
    check(remainder == '0, "R1 reset remainder", 64'(remainder), 64'd0);
  endtask

  task automatic t_boundaries();
    t_divide(30'd5, 30'd7, "R8 small dividend");
    t_divide(30'd123456789, 30'd1, "R8 divisor one");
    t_divide(30'd0, 30'd9, "R8 zero dividend");
    t_divide(ONES, ONES, "R8 all ones");
    t_divide(ONES, 30'd1 << (W - 1), "R8 top-bit divisor");
    t_divide(ONES, 30'd3, "R7 many ones");
  endtask

  task automatic t_random(input int count);
    for (int i = 0; i < count; i++) begin
      logic [W-1:0] n;
      logic [W-1:0] d;
      n = W'($urandom);
      d = W'($urandom) >> ($urandom % W);
      if (d == '0) d = 30'd1;
      t_divide(n, d, "R3 R7 random");
    end
  endtask

  task automatic t_busy_start();
    int cyc;
    @(negedge clk);
    dividend = 30'd1000000;
    divisor  = 30'd37;
    start    = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cyc = 0;
    repeat (100) begin @(posedge clk); cyc++; end
    @(negedge clk);
    dividend = 30'd77;
    divisor  = 30'd5;
    start    = 1'b1;
    @(posedge clk);
    cyc++;
    #1 start = 1'b0;
    while (!done && cyc < LAT + 20) begin
      @(posedge clk);
      cyc++;
      #1;
    end
    check(cyc == LAT, "R5 latency unchanged", 64'(cyc), 64'(LAT));
    check(quotient == 30'd27027, "R5 quotient of first operands", 64'(quotient), 64'd27027);
    check(remainder == 30'd1, "R5 remainder of first operands", 64'(remainder), 64'd1);
  endtask

  task automatic t_hold();
    logic [W-1:0] q0;
    logic [W-1:0] r0;
    t_divide(30'd999999, 30'd1000, "R6 setup");
    q0 = quotient;
    r0 = remainder;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      dividend = W'($urandom);
      divisor  = W'($urandom);
    end
    #1;
    check(done == 1'b1, "R6 done held", 64'(done), 64'd1);
    check(quotient == q0, "R6 quotient held", 64'(quotient), 64'(q0));
    check(remainder == r0, "R6 remainder held", 64'(remainder), 64'(r0));
  endtask

  initial begin
    #(20 * 180000);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_divide(30'd100, 30'd7, "R3 basic");
    t_boundaries();
    t_random(40);
    t_busy_start();
    t_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule